// File: doc/BRIEF.md
# Dual-Issue Pairing Check Unit

This block looks at the next two instructions of one thread, in program order, and decides in the same cycle how many of them go into the pipeline. The older instruction, slot A, may go to the primary pipe. The younger one, slot B, may go to the secondary pipe beside it. The decision is purely combinational: the front end presents both decoded instructions, and it reads back two issue flags and a count of instructions consumed (0, 1 or 2).

Slot A can carry an instruction of any class. The secondary pipe is smaller, so it accepts only the classes marked in a parameter table. The two instructions are held back from pairing under any of these conditions:
- slot B depends on slot A's result;
- slot B is not ready;
- slot A is a branch.

A busy vector supplied from outside marks registers whose values are still in flight. A busy source on slot A stalls both slots. The outcome is a fixed function of the two instructions and the busy vector, so a compiler can schedule pairs ahead of time and know the result.

Top module: `pair_issue`

## Requirements
- R1: When `a_vld` is 1 and no source of slot A is busy, `iss_pri` is 1 for every value of `a_cls`.
- R2: `iss_sec` is 1 only when bit `b_cls` of the parameter `SEC_OK` is set. The default `16'h003D` marks classes 0, 2, 3, 4 and 5 as eligible for the secondary pipe.
- R3: `iss_sec` is never 1 while `iss_pri` is 0. Issue stays in program order.
- R4: `consumed` equals `iss_pri + iss_sec` and never exceeds 2.
- R5: If `a_rd` is nonzero and equals `b_rs1`, `b_rs2` or `b_rd`, only slot A issues.
- R6: If `a_cls` equals `BR_CLS` (default 2), slot B does not issue. A branch in slot B may still pair.
- R7: If `busy[a_rs1]` or `busy[a_rs2]` is set for a nonzero register number, neither slot issues.
- R8: If `busy[b_rs1]` or `busy[b_rs2]` is set for a nonzero register number, slot B does not issue.
- R9: Register 0 never creates a hazard, and bit 0 of `busy` is ignored.
- R10: With `a_vld` at 0 nothing issues, even when `b_vld` is 1. With `b_vld` at 0 slot B does not issue.
- R11: When none of the conditions in R2, R5, R6, R7, R8 or R10 blocks slot B, both instructions issue and `consumed` is 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_vld | input | 1 | Slot A (older instruction) present |
| a_cls | input | CLS_W | Slot A instruction class |
| a_rs1 | input | RW | Slot A first source register |
| a_rs2 | input | RW | Slot A second source register |
| a_rd | input | RW | Slot A destination register |
| b_vld | input | 1 | Slot B (younger instruction) present |
| b_cls | input | CLS_W | Slot B instruction class |
| b_rs1 | input | RW | Slot B first source register |
| b_rs2 | input | RW | Slot B second source register |
| b_rd | input | RW | Slot B destination register |
| busy | input | NREG | One bit per register, set while that register's value is in flight |
| iss_pri | output | 1 | Slot A issues to the primary pipe |
| iss_sec | output | 1 | Slot B issues to the secondary pipe |
| consumed | output | 2 | Number of instructions taken this cycle |

## Verification
The bench uses an eight-register build and runs three sweeps.

1. **Class sweep.** Every slot A class is crossed with every slot B class and all four valid-flag combinations, using register fields that share nothing. This isolates the eligibility table, the branch-first rule and the valid gating.
2. **Register sweep.** Every value of slot A's destination is crossed with every value of slot B's three register fields. This tells a true dependence apart from a harmless match on register 0.
3. **Busy sweep.** Every busy vector is crossed with every choice of slot A and slot B first source. This separates a full stall from a single issue, and checks that bit 0 of `busy` is ignored.

// File: rtl/pair_issue.sv
module pair_issue #(
  parameter int NREG = 32,
  parameter int CLS_W = 4,
  parameter logic [(1<<CLS_W)-1:0] SEC_OK = 16'h003D,
  parameter logic [CLS_W-1:0] BR_CLS = 4'd2,
  localparam int RW = $clog2(NREG)
) (
  input  logic             a_vld,
  input  logic [CLS_W-1:0] a_cls,
  input  logic [RW-1:0]    a_rs1,
  input  logic [RW-1:0]    a_rs2,
  input  logic [RW-1:0]    a_rd,
  input  logic             b_vld,
  input  logic [CLS_W-1:0] b_cls,
  input  logic [RW-1:0]    b_rs1,
  input  logic [RW-1:0]    b_rs2,
  input  logic [RW-1:0]    b_rd,
  input  logic [NREG-1:0]  busy,
  output logic             iss_pri,
  output logic             iss_sec,
  output logic [1:0]       consumed
);

  logic [NREG-1:0] bsy;
  assign bsy = {busy[NREG-1:1], 1'b0};

  logic a_wait, b_wait, dep, pair_ok;

  assign a_wait = bsy[a_rs1] | bsy[a_rs2];
  assign b_wait = bsy[b_rs1] | bsy[b_rs2];

  assign dep = (a_rd != '0) &&
               ((b_rs1 == a_rd) || (b_rs2 == a_rd) || (b_rd == a_rd));

  assign pair_ok = b_vld && SEC_OK[b_cls] && (a_cls != BR_CLS) && !dep && !b_wait;

  assign iss_pri  = a_vld & ~a_wait;
  assign iss_sec  = iss_pri & pair_ok;
  assign consumed = {1'b0, iss_pri} + {1'b0, iss_sec};

endmodule

// File: rtl/pair_issue_chk.sv
module pair_issue_chk #(
  parameter int NREG = 32,
  parameter int CLS_W = 4,
  parameter logic [(1<<CLS_W)-1:0] SEC_OK = 16'h003D,
  parameter logic [CLS_W-1:0] BR_CLS = 4'd2,
  localparam int RW = $clog2(NREG)
) (
  input logic             a_vld,
  input logic [CLS_W-1:0] a_cls,
  input logic [RW-1:0]    a_rs1,
  input logic [RW-1:0]    a_rd,
  input logic             b_vld,
  input logic [CLS_W-1:0] b_cls,
  input logic [RW-1:0]    b_rs1,
  input logic [RW-1:0]    b_rs2,
  input logic [RW-1:0]    b_rd,
  input logic [NREG-1:0]  busy,
  input logic             iss_pri,
  input logic             iss_sec,
  input logic [1:0]       consumed
);
  always_comb begin
    AST_SEC_CLASS: assert (!iss_sec || SEC_OK[b_cls]); // R2
    AST_IN_ORDER: assert (!iss_sec || iss_pri); // R3
    AST_MAX_TWO: assert (consumed != 2'd3); // R4
    AST_NO_DEP: assert (!iss_sec || a_rd == '0 || (b_rs1 != a_rd && b_rs2 != a_rd && b_rd != a_rd)); // R5
    AST_NO_BR_FIRST: assert (!iss_sec || a_cls != BR_CLS); // R6
    AST_BUSY_STALL: assert (!(a_rs1 != '0 && busy[a_rs1]) || !iss_pri); // R7
    AST_VALID_GATE: assert ((a_vld || !iss_pri) && (b_vld || !iss_sec)); // R10
  end
endmodule

bind pair_issue pair_issue_chk #(
  .NREG(NREG), .CLS_W(CLS_W), .SEC_OK(SEC_OK), .BR_CLS(BR_CLS)
) u_chk (
  .a_vld(a_vld), .a_cls(a_cls), .a_rs1(a_rs1), .a_rd(a_rd),
  .b_vld(b_vld), .b_cls(b_cls), .b_rs1(b_rs1), .b_rs2(b_rs2), .b_rd(b_rd),
  .busy(busy), .iss_pri(iss_pri), .iss_sec(iss_sec), .consumed(consumed)
);

// File: tb/pair_issue_tb.sv
module pair_issue_tb;
  localparam int NREG = 8;
  localparam int RW = 3;
  localparam logic [15:0] SEC_TBL = 16'h003D;
  localparam logic [3:0] BRC = 4'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic a_vld, b_vld;
  logic [3:0] a_cls, b_cls;
  logic [RW-1:0] a_rs1, a_rs2, a_rd, b_rs1, b_rs2, b_rd;
  logic [NREG-1:0] busy;
  logic iss_pri, iss_sec;
  logic [1:0] consumed;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  pair_issue #(.NREG(NREG)) u_dut (
    .a_vld(a_vld), .a_cls(a_cls), .a_rs1(a_rs1), .a_rs2(a_rs2), .a_rd(a_rd),
    .b_vld(b_vld), .b_cls(b_cls), .b_rs1(b_rs1), .b_rs2(b_rs2), .b_rd(b_rd),
    .busy(busy), .iss_pri(iss_pri), .iss_sec(iss_sec), .consumed(consumed)
  );

  function automatic bit bz(input logic [RW-1:0] r);
    return (r != 0) && busy[r];
  endfunction

  task automatic apply_check(input string req);
    logic ep, es;
    logic [1:0] ec;
    @(posedge clk);
    ep = a_vld && !bz(a_rs1) && !bz(a_rs2);
    es = ep && b_vld && SEC_TBL[b_cls] && (a_cls != BRC)
         && !(a_rd != 0 && (b_rs1 == a_rd || b_rs2 == a_rd || b_rd == a_rd))
         && !bz(b_rs1) && !bz(b_rs2);
    ec = 2'(int'(ep) + int'(es));
    @(negedge clk);
    tests++;
    if (iss_pri !== ep || iss_sec !== es || consumed !== ec) begin
      fails++;
      $display("FAIL %s: got pri=%b sec=%b cnt=%0d expected pri=%b sec=%b cnt=%0d (acls=%0d bcls=%0d ard=%0d brs=%0d/%0d brd=%0d busy=%b)",
               req, iss_pri, iss_sec, consumed, ep, es, ec,
               a_cls, b_cls, a_rd, b_rs1, b_rs2, b_rd, busy);
    end
  endtask

  initial begin
    a_vld = 0; b_vld = 0; a_cls = 0; b_cls = 0;
    a_rs1 = 0; a_rs2 = 0; a_rd = 0; b_rs1 = 0; b_rs2 = 0; b_rd = 0; busy = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tests++;
    if (iss_pri !== 0 || iss_sec !== 0 || consumed !== 0) begin
      fails++;
      $display("FAIL R10 idle: got %b%b %0d expected 00 0", iss_pri, iss_sec, consumed);
    end

    // R1 R2 R6 R10 R11: class sweep with independent registers
    a_rs1 = 1; a_rs2 = 2; a_rd = 3; b_rs1 = 4; b_rs2 = 5; b_rd = 6;
    for (int v = 0; v < 4; v++)
      for (int ca = 0; ca < 16; ca++)
        for (int cb = 0; cb < 16; cb++) begin
          a_vld = v[0]; b_vld = v[1]; a_cls = 4'(ca); b_cls = 4'(cb);
          apply_check("R1/R2/R6/R10/R11 class");
        end

    // R5 R9: register dependence sweep
    a_vld = 1; b_vld = 1; a_cls = 0; b_cls = 0; a_rs1 = 1; a_rs2 = 2;
    for (int d = 0; d < NREG; d++)
      for (int s1 = 0; s1 < NREG; s1++)
        for (int s2 = 0; s2 < NREG; s2++)
          for (int w = 0; w < NREG; w++) begin
            a_rd = RW'(d); b_rs1 = RW'(s1); b_rs2 = RW'(s2); b_rd = RW'(w);
            apply_check("R5/R9 dependence");
          end

    // R7 R8 R9: busy vector sweep
    a_rd = 0; b_rd = 0; a_rs2 = 0; b_rs2 = 3;
    for (int bv = 0; bv < (1 << NREG); bv++)
      for (int x = 0; x < NREG; x++)
        for (int y = 0; y < NREG; y++) begin
          busy = NREG'(bv); a_rs1 = RW'(x); b_rs1 = RW'(y);
          apply_check("R7/R8/R9 busy");
        end

    // R3 R4: spot check of ordering with slot A stalled while slot B is ready
    busy = 8'h02; a_rs1 = 1; b_rs1 = 4; b_rs2 = 5;
    apply_check("R3/R4 order");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule